// File: doc/BRIEF.md
# Device-to-Host Frame Receive Writer

This block sits on the receive side of one port of a serial storage host adapter. Device-to-host frames arrive one byte per transfer over a valid/ready stream, with `inLast` marking the final byte. The first byte of each frame is its type code. For a recognised type, the block copies the frame into a 256-byte receive-area RAM at a fixed window. When the frame ends, it takes one extra cycle to apply the frame to the port state: the task-file status, the interrupt-status bits, the set of active queued slots, an error record and a sticky error-wait flag.

Three frame types are handled: the register frame, the set-device-bits frame and the PIO-setup frame. A frame may ask for an interrupt through its flag byte, and the type-specific interrupt bit follows that flag. An error status always raises a task-file-error interrupt. It also latches the error-wait flag, which tells the command-issue logic to stop until the port is stopped. The command-issue and host logic can preload the task file, mark slots active and clear interrupt bits with a write-one-to-clear mask.

Top module: `fisrx_writer`

## Requirements
- R1: A register frame (code 0x34) is written at RAM offsets 0x40..0x53 (20 bytes), a PIO-setup frame (code 0x5F) at 0x20..0x33 (20 bytes) and a set-device-bits frame (code 0xA1) at 0x58..0x5F (8 bytes). Frame byte k goes to base+k, and bytes beyond the type's length are accepted but not written.
- R2: A frame whose first byte is any other code is consumed up to `inLast` with no RAM write and no change to any register output.
- R3: Interrupt-status bit 0 (register frame), bit 1 (PIO-setup) or bit 2 (set-device-bits) is set at commit only when bit 6 of frame byte 1 is 1.
- R4: When bit 0 (error) of the status byte (frame byte 2) is 1, commit sets interrupt bit 3 and latches `errWait`. `portStop` clears `errWait`, and a commit in the same cycle wins.
- R5: A register or PIO-setup commit loads `tfdStat` with {byte 3, byte 2}.
- R6: A set-device-bits commit replaces only the `tfdStat` bits selected by mask 0x77 with the status byte's bits. All other task-file bits keep their values.
- R7: A set-device-bits commit without error clears every `sactStat` bit that is set in the 32-bit completion mask held in bytes 4..7 (byte 4 = bits 7:0). With an error, `sactStat` is unchanged.
- R8: An error commit loads the error record. The slot is `curSlot` for a set-device-bits frame and 0x80 otherwise. The status is masked with 0x77 for a set-device-bits frame and taken whole otherwise. The error code is byte 3.
- R9: Interrupt bits are set-only. `isrClr` clears the bits it selects, and a set in the same cycle wins.
- R10: `inReady` is high except for exactly one commit cycle that follows the last byte of a recognised frame. Commit effects are visible on the clock edge that ends that cycle. Bytes missing from a short frame count as zero.
- R11: `tfdLoad` loads `tfdStat` from `tfdLoadVal` (a commit in the same cycle wins), and `sactSet` ORs bits into `sactStat` before any commit clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Frame byte valid |
| inReady | output | 1 | Frame byte accepted when high with inValid |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | Marks the final byte of a frame |
| curSlot | input | 5 | Slot of the queued command in progress |
| isrClr | input | 4 | Write-one-to-clear mask for interrupt status |
| tfdLoad | input | 1 | Load strobe for the task file |
| tfdLoadVal | input | 16 | Value loaded into the task file |
| sactSet | input | 32 | Bits to mark active in the queued-slot register |
| portStop | input | 1 | Port stop; releases the error-wait flag |
| ramWe | output | 1 | Receive-area write enable |
| ramAddr | output | 8 | Receive-area byte address |
| ramData | output | 8 | Receive-area write data |
| isrStat | output | 4 | Interrupt status: bit0 register, bit1 PIO, bit2 device-bits, bit3 task-file error |
| tfdStat | output | 16 | Task file: error byte 15:8, status 7:0 |
| sactStat | output | 32 | Active queued slots |
| errWait | output | 1 | Sticky error-wait flag |
| errSlot | output | 8 | Error record slot |
| errStatus | output | 8 | Error record status |
| errCode | output | 8 | Error record error byte |

## Verification
The assertions assume that the task file changes only through a frame commit or `tfdLoad`. They also assume that the stream is framed by `inLast`, so that a commit cycle always follows a recognised frame. The stimulus keeps to this: it drives byte streams with gaps and back-to-back frames, holds `inValid` through the commit cycle, and changes the side inputs only at cycle boundaries. Corner cases covered include short and over-long frames, unknown codes, a clear that coincides with a set, and a stop that coincides with an error commit.

// File: rtl/fisrx_pkg.sv
package fisrx_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_REG  = 2'd1,
    KIND_PIO  = 2'd2,
    KIND_SDB  = 2'd3
  } fisKind_t;

  localparam logic [7:0] CODE_REG = 8'h34;
  localparam logic [7:0] CODE_PIO = 8'h5F;
  localparam logic [7:0] CODE_SDB = 8'hA1;

  localparam int IRQ_REG = 0;
  localparam int IRQ_PIO = 1;
  localparam int IRQ_SDB = 2;
  localparam int IRQ_TFE = 3;
  localparam int IRQ_W   = 4;

  localparam int STAT_ERR_BIT = 0;
  localparam int FLAG_IRQ_BIT = 6;
  localparam logic [7:0] SDB_STAT_MASK = 8'h77;
  localparam logic [7:0] NONQ_SLOT     = 8'h80;

  // control -> datapath strobes
  typedef struct packed {
    logic     wr;
    logic     start;
    logic     cap;
    logic     commit;
    fisKind_t kind;
  } fisStb_t;

  function automatic fisKind_t decodeKind(input logic [7:0] code);
    case (code)
      CODE_REG: return KIND_REG;
      CODE_PIO: return KIND_PIO;
      CODE_SDB: return KIND_SDB;
      default:  return KIND_NONE;
    endcase
  endfunction

  function automatic logic [7:0] baseOf(input fisKind_t k);
    case (k)
      KIND_REG: return 8'h40;
      KIND_PIO: return 8'h20;
      KIND_SDB: return 8'h58;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] lenOf(input fisKind_t k);
    case (k)
      KIND_REG: return 8'd20;
      KIND_PIO: return 8'd20;
      KIND_SDB: return 8'd8;
      default:  return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/fisrx_ctrl.sv
module fisrx_ctrl
  import fisrx_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic [7:0]       inData,
  output logic             inReady,
  output fisStb_t          stb,
  output logic [IDX_W-1:0] byteIdx
);

  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_DROP, ST_COMMIT} state_t;

  state_t           state;
  fisKind_t         kindReg;
  logic [IDX_W-1:0] idxReg;
  fisKind_t         firstKind;
  logic             hs;

  assign inReady   = (state != ST_COMMIT);
  assign hs        = inValid && inReady;
  assign firstKind = decodeKind(inData);

  always_comb begin
    stb        = '0;
    stb.kind   = (state == ST_IDLE) ? firstKind : kindReg;
    stb.start  = hs && (state == ST_IDLE);
    stb.cap    = hs && (state == ST_BODY);
    stb.commit = (state == ST_COMMIT);
    stb.wr     = hs && (((state == ST_IDLE) && (firstKind != KIND_NONE)) ||
                        ((state == ST_BODY) && (int'(idxReg) < int'(lenOf(kindReg)))));
    byteIdx    = (state == ST_IDLE) ? '0 : idxReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindReg <= KIND_NONE;
      idxReg  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (hs) begin
          kindReg <= firstKind;
          idxReg  <= IDX_W'(1);
          if (firstKind == KIND_NONE) state <= inLast ? ST_IDLE : ST_DROP;
          else                        state <= inLast ? ST_COMMIT : ST_BODY;
        end
        ST_BODY: if (hs) begin
          if (idxReg != IDX_MAX) idxReg <= idxReg + 1'b1;
          if (inLast) state <= ST_COMMIT;
        end
        ST_DROP: if (hs && inLast) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fisrx_datapath.sv
module fisrx_datapath
  import fisrx_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fisStb_t                  stb,
  input  logic [IDX_W-1:0]         byteIdx,
  input  logic [7:0]               inData,
  input  logic [$clog2(SLOTS)-1:0] curSlot,
  input  logic [IRQ_W-1:0]         isrClr,
  input  logic                     tfdLoad,
  input  logic [15:0]              tfdLoadVal,
  input  logic [SLOTS-1:0]         sactSet,
  input  logic                     portStop,
  output logic                     ramWe,
  output logic [ADDR_W-1:0]        ramAddr,
  output logic [7:0]               ramData,
  output logic [IRQ_W-1:0]         isrStat,
  output logic [15:0]              tfdStat,
  output logic [SLOTS-1:0]         sactStat,
  output logic                     errWait,
  output logic [7:0]               errSlot,
  output logic [7:0]               errStatus,
  output logic [7:0]               errCode
);

  logic [7:0]       flagsB, statB, errB;
  logic [31:0]      maskB;
  logic             errHit, isSdb;
  logic [IRQ_W-1:0] setBits;
  logic [SLOTS-1:0] sactNext;

  assign ramWe   = stb.wr;
  assign ramAddr = ADDR_W'(baseOf(stb.kind)) + ADDR_W'(byteIdx);
  assign ramData = inData;

  // header bytes captured as they stream past
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsB <= '0; statB <= '0; errB <= '0; maskB <= '0;
    end else if (stb.start) begin
      flagsB <= '0; statB <= '0; errB <= '0; maskB <= '0;
    end else if (stb.cap) begin
      case (int'(byteIdx))
        1: flagsB       <= inData;
        2: statB        <= inData;
        3: errB         <= inData;
        4: maskB[7:0]   <= inData;
        5: maskB[15:8]  <= inData;
        6: maskB[23:16] <= inData;
        7: maskB[31:24] <= inData;
        default: ;
      endcase
    end
  end

  assign errHit = statB[STAT_ERR_BIT];
  assign isSdb  = (stb.kind == KIND_SDB);

  always_comb begin
    setBits = '0;
    if (stb.commit) begin
      if (flagsB[FLAG_IRQ_BIT]) begin
        case (stb.kind)
          KIND_REG: setBits[IRQ_REG] = 1'b1;
          KIND_PIO: setBits[IRQ_PIO] = 1'b1;
          KIND_SDB: setBits[IRQ_SDB] = 1'b1;
          default:  ;
        endcase
      end
      if (errHit) setBits[IRQ_TFE] = 1'b1;
    end
  end

  always_comb begin
    sactNext = sactStat | sactSet;
    if (stb.commit && isSdb && !errHit) sactNext = sactNext & ~maskB[SLOTS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrStat   <= '0;
      tfdStat   <= '0;
      sactStat  <= '0;
      errWait   <= 1'b0;
      errSlot   <= '0;
      errStatus <= '0;
      errCode   <= '0;
    end else begin
      isrStat  <= (isrStat & ~isrClr) | setBits;
      sactStat <= sactNext;
      if (stb.commit && isSdb)
        tfdStat <= {tfdStat[15:8], (tfdStat[7:0] & ~SDB_STAT_MASK) | (statB & SDB_STAT_MASK)};
      else if (stb.commit)
        tfdStat <= {errB, statB};
      else if (tfdLoad)
        tfdStat <= tfdLoadVal;
      if (stb.commit && errHit) begin
        errWait   <= 1'b1;
        errSlot   <= isSdb ? 8'(curSlot) : NONQ_SLOT;
        errStatus <= isSdb ? (statB & SDB_STAT_MASK) : statB;
        errCode   <= errB;
      end else if (portStop) begin
        errWait <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fisrx_writer.sv
module fisrx_writer
  import fisrx_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [7:0]               inData,
  input  logic                     inLast,
  input  logic [$clog2(SLOTS)-1:0] curSlot,
  input  logic [3:0]               isrClr,
  input  logic                     tfdLoad,
  input  logic [15:0]              tfdLoadVal,
  input  logic [SLOTS-1:0]         sactSet,
  input  logic                     portStop,
  output logic                     ramWe,
  output logic [ADDR_W-1:0]        ramAddr,
  output logic [7:0]               ramData,
  output logic [3:0]               isrStat,
  output logic [15:0]              tfdStat,
  output logic [SLOTS-1:0]         sactStat,
  output logic                     errWait,
  output logic [7:0]               errSlot,
  output logic [7:0]               errStatus,
  output logic [7:0]               errCode
);

  fisStb_t          stb;
  logic [IDX_W-1:0] byteIdx;

  fisrx_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inData(inData),
    .inReady(inReady), .stb(stb), .byteIdx(byteIdx)
  );

  fisrx_datapath #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIdx(byteIdx), .inData(inData),
    .curSlot(curSlot), .isrClr(isrClr), .tfdLoad(tfdLoad), .tfdLoadVal(tfdLoadVal),
    .sactSet(sactSet), .portStop(portStop), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramData(ramData), .isrStat(isrStat), .tfdStat(tfdStat), .sactStat(sactStat),
    .errWait(errWait), .errSlot(errSlot), .errStatus(errStatus), .errCode(errCode)
  );

endmodule

// File: rtl/fisrx_writer_chk.sv
module fisrx_writer_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              tfdLoad,
  input logic [3:0]        isrClr,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [3:0]        isrStat,
  input logic [15:0]       tfdStat,
  input logic              errWait
);

  p_ram_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ((int'(ramAddr) >= 'h20 && int'(ramAddr) <= 'h33) ||
               (int'(ramAddr) >= 'h40 && int'(ramAddr) <= 'h53) ||
               (int'(ramAddr) >= 'h58 && int'(ramAddr) <= 'h5F)));

  p_ram_on_handshake_r10: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (inValid && inReady));

  p_ready_single_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> inReady);

  p_isr_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((isrStat & $past(isrStat & ~isrClr)) == $past(isrStat & ~isrClr)));

  p_wait_with_tfe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errWait) |-> isrStat[3]);

  p_tfd_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !tfdLoad) |=> $stable(tfdStat));

endmodule

bind fisrx_writer fisrx_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .tfdLoad(tfdLoad),
  .isrClr(isrClr), .ramWe(ramWe), .ramAddr(ramAddr), .isrStat(isrStat),
  .tfdStat(tfdStat), .errWait(errWait)
);

// File: tb/fisrx_writer_tb.sv
module fisrx_writer_tb;

  typedef logic [7:0] bytes_t[$];

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inLast = 1'b0, tfdLoad = 1'b0, portStop = 1'b0;
  logic [7:0]  inData = '0;
  logic [4:0]  curSlot = '0;
  logic [3:0]  isrClr = '0;
  logic [15:0] tfdLoadVal = '0;
  logic [31:0] sactSet = '0;
  logic        inReady, ramWe, errWait;
  logic [7:0]  ramAddr, ramData, errSlot, errStatus, errCode;
  logic [3:0]  isrStat;
  logic [15:0] tfdStat;
  logic [31:0] sactStat;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // reference model state
  logic [3:0]  mIsr = '0;
  logic [15:0] mTfd = '0;
  logic [31:0] mSact = '0;
  logic        mWait = 1'b0;
  logic [7:0]  mRecSlot = '0, mRecSt = '0, mRecEr = '0;
  logic [7:0]  mB[8];
  int          mKind = 0, mIdx = 0;
  bit          mInFrame = 0, mCommit = 0, lastHs = 0;

  always #4 clk = ~clk;

  fisrx_writer u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .curSlot(curSlot), .isrClr(isrClr), .tfdLoad(tfdLoad),
    .tfdLoadVal(tfdLoadVal), .sactSet(sactSet), .portStop(portStop), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramData(ramData), .isrStat(isrStat), .tfdStat(tfdStat),
    .sactStat(sactStat), .errWait(errWait), .errSlot(errSlot), .errStatus(errStatus),
    .errCode(errCode)
  );

  function automatic int kindOf(input logic [7:0] c);
    if (c == 8'h34) return 1;
    if (c == 8'h5F) return 2;
    if (c == 8'hA1) return 3;
    return 0;
  endfunction
  function automatic int baseFor(input int k);
    return (k == 1) ? 'h40 : (k == 2) ? 'h20 : 'h58;
  endfunction
  function automatic int lenFor(input int k);
    return (k == 3) ? 8 : 20;
  endfunction

  function automatic bytes_t mkFrame(input logic [7:0] code, flg, st, er,
                                     input logic [31:0] mask, input int n);
    bytes_t q;
    for (int i = 0; i < n; i++) begin
      case (i)
        0: q.push_back(code);
        1: q.push_back(flg);
        2: q.push_back(st);
        3: q.push_back(er);
        4: q.push_back(mask[7:0]);
        5: q.push_back(mask[15:8]);
        6: q.push_back(mask[23:16]);
        7: q.push_back(mask[31:24]);
        default: q.push_back(8'(8'hC0 + i));
      endcase
    end
    return q;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpRegs();
    chk(isrStat == mIsr, "R3/R4/R9 isrStat", 64'(isrStat), 64'(mIsr));
    chk(tfdStat == mTfd, "R5/R6/R11 tfdStat", 64'(tfdStat), 64'(mTfd));
    chk(sactStat == mSact, "R7/R11 sactStat", 64'(sactStat), 64'(mSact));
    chk(errWait == mWait, "R4 errWait", 64'(errWait), 64'(mWait));
    chk({errSlot, errStatus, errCode} == {mRecSlot, mRecSt, mRecEr}, "R8 error record",
        64'({errSlot, errStatus, errCode}), 64'({mRecSlot, mRecSt, mRecEr}));
  endtask

  // one clock: inputs already driven after a falling edge
  task automatic tick();
    bit expReady, expWe, commitNext;
    int expAddr, k;
    logic [3:0]  nIsr;
    logic [15:0] nTfd;
    logic [31:0] nSact, mk;
    logic        nWait;
    logic [7:0]  st;
    #1;
    expReady = !mCommit;
    chk(inReady == expReady, "R10 inReady", 64'(inReady), 64'(expReady));
    lastHs = inValid && expReady;
    expWe = 0; expAddr = 0;
    if (lastHs) begin
      if (!mInFrame) begin
        k = kindOf(inData);
        if (k != 0) begin expWe = 1; expAddr = baseFor(k); end
      end else if (mKind != 0 && mIdx < lenFor(mKind)) begin
        expWe = 1; expAddr = baseFor(mKind) + mIdx;
      end
    end
    chk(ramWe == expWe, "R1/R2 ramWe", 64'(ramWe), 64'(expWe));
    if (expWe) begin
      chk(ramAddr == 8'(expAddr), "R1 ramAddr", 64'(ramAddr), 64'(expAddr));
      chk(ramData == inData, "R1 ramData", 64'(ramData), 64'(inData));
    end
    // next state
    nIsr = mIsr & ~isrClr;
    nTfd = tfdLoad ? tfdLoadVal : mTfd;
    nSact = mSact | sactSet;
    nWait = portStop ? 1'b0 : mWait;
    if (mCommit) begin
      st = mB[2];
      mk = {mB[7], mB[6], mB[5], mB[4]};
      if (mB[1][6]) nIsr[mKind - 1] = 1'b1;
      if (st[0]) begin
        nIsr[3] = 1'b1; nWait = 1'b1;
        mRecSlot = (mKind == 3) ? 8'(curSlot) : 8'h80;
        mRecSt   = (mKind == 3) ? (st & 8'h77) : st;
        mRecEr   = mB[3];
      end
      if (mKind == 3) begin
        nTfd = {mTfd[15:8], (mTfd[7:0] & 8'h88) | (st & 8'h77)};
        if (!st[0]) nSact = nSact & ~mk;
      end else begin
        nTfd = {mB[3], st};
      end
    end
    commitNext = 0;
    if (lastHs) begin
      if (!mInFrame) begin
        mKind = kindOf(inData);
        for (int i = 0; i < 8; i++) mB[i] = '0;
        mB[0] = inData; mIdx = 1;
        mInFrame = !inLast;
        if (inLast && mKind != 0) commitNext = 1;
      end else begin
        if (mIdx < 8) mB[mIdx] = inData;
        mIdx++;
        if (inLast) begin mInFrame = 0; if (mKind != 0) commitNext = 1; end
      end
    end
    mCommit = commitNext;
    mIsr = nIsr; mTfd = nTfd; mSact = nSact; mWait = nWait;
    @(posedge clk);
    @(negedge clk);
    cmpRegs();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sendFrame(input bytes_t b);
    for (int i = 0; i < b.size(); i++) begin
      inValid = 1'b1; inData = b[i]; inLast = (i == b.size() - 1);
      do tick(); while (!lastHs);
    end
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mB[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cmpRegs();                                    // reset state (R10)
    idle(2);
    // R3 R5: register frame with interrupt
    sendFrame(mkFrame(8'h34, 8'h40, 8'h50, 8'h00, 32'h0, 20)); idle(2);
    // R9: clear all, then register frame without interrupt (R3)
    isrClr = 4'hF; idle(1); isrClr = 4'h0;
    sendFrame(mkFrame(8'h34, 8'h00, 8'h58, 8'h00, 32'h0, 20)); idle(1);
    // R3: PIO-setup with interrupt
    sendFrame(mkFrame(8'h5F, 8'h40, 8'h58, 8'h00, 32'h0, 20)); idle(1);
    // R11: preload task file and active slots
    tfdLoad = 1'b1; tfdLoadVal = 16'h1288; sactSet = 32'h0000_00F0; idle(1);
    tfdLoad = 1'b0; sactSet = '0;
    // R6 R7: device-bits success for slot 5
    sendFrame(mkFrame(8'hA1, 8'h40, 8'h40, 8'h00, 32'h0000_0020, 8)); idle(2);
    // R4 R8: device-bits error for slot 7, sact stays
    curSlot = 5'd7;
    sendFrame(mkFrame(8'hA1, 8'h40, 8'h41, 8'h04, 32'h0000_0080, 8)); idle(2);
    // R9: clear held during a setting commit, set wins
    isrClr = 4'hF; sendFrame(mkFrame(8'h34, 8'h40, 8'h50, 8'h00, 32'h0, 20)); idle(1);
    isrClr = 4'h0;
    // R2: unknown code dropped
    sendFrame(mkFrame(8'h27, 8'h40, 8'h41, 8'h09, 32'hFFFF_FFFF, 10)); idle(2);
    // R1: over-long frame, short frame (R10 missing bytes zero)
    sendFrame(mkFrame(8'h34, 8'h40, 8'h50, 8'h00, 32'h0, 25));
    sendFrame(mkFrame(8'hA1, 8'h40, 8'h41, 8'h00, 32'h0, 3)); idle(1);
    // R4: stop releases wait
    portStop = 1'b1; idle(1); portStop = 1'b0; idle(1);
    // R8: non-queued error record
    sendFrame(mkFrame(8'h34, 8'h00, 8'h51, 8'h0A, 32'h0, 20)); idle(1);
    // R4: stop held across an error commit, commit wins
    portStop = 1'b1; sendFrame(mkFrame(8'h5F, 8'h00, 8'h59, 8'h02, 32'h0, 20)); idle(1);
    portStop = 1'b0;
    // R10: back-to-back frames, valid held through commit
    sactSet = 32'h0000_0300; idle(1); sactSet = '0;
    sendFrame(mkFrame(8'h5F, 8'h40, 8'h50, 8'h00, 32'h0, 20));
    sendFrame(mkFrame(8'hA1, 8'h40, 8'h40, 8'h00, 32'h0000_0100, 8));
    sendFrame(mkFrame(8'hA1, 8'h00, 8'h00, 8'h00, 32'h0, 1)); idle(3);
    // R11: load and commit in the same cycle, commit wins
    tfdLoad = 1'b1; tfdLoadVal = 16'hBEEF;
    sendFrame(mkFrame(8'h34, 8'h00, 8'h50, 8'h00, 32'h0, 20)); idle(1);
    tfdLoad = 1'b0; idle(2);
    finished = 1;
    summary();
    $finish;
  end

endmodule